// File: doc/BRIEF.md
# Nibble ALU with Flag Register

This block is the arithmetic core of a small accumulator machine. It takes an operation code, the accumulator value and a second operand. It returns a result of the operand width, 4 bits by default. It also keeps a four-bit flag register: carry (C), zero (Z), status (S) and general (G). The operations are:

- add, with or without carry-in
- subtract, with or without borrow-in
- compare
- rotate left or right through carry
- two carry-test operations
- set, clear and test of the general flag

The status flag is the flag a following conditional branch tests. After any arithmetic operation it holds the inverse of the new carry. On subtract and compare, the carry flag means "no borrow": it is 1 when no borrow occurred and 0 when one did.

The result is combinational from the current inputs and the stored flags. The flags change on the next rising clock edge. For interrupt entry, the surrounding controller reads and saves `flags_o` directly. For return from interrupt, it writes the saved value back through the restore port. Instruction decoding, registers and memory stay outside the block.

Top module: `nalu_core`

## Requirements
- R1: Op code 1 (ADD) returns the low 4 bits of acc+opnd, and op code 2 (ADC) returns the low 4 bits of acc+opnd+C. In both cases C takes the carry out of bit 3.
- R2: Op code 3 (SUB) returns acc-opnd, and op code 4 (SBC) returns acc-opnd-(1-C), both modulo 16. In both cases C becomes 1 when no borrow occurs and 0 when one does.
- R3: Op code 5 (CMP) sets the flags exactly as SUB would, and res_o equals the accumulator.
- R4: After ops 1 to 7, Z is 1 exactly when the 4-bit outcome is zero. For CMP the outcome is the difference. For example, 8+8 gives result 0 with C=1 and Z=1.
- R5: After ops 1 to 5, S equals the inverse of the new C. For example, 3+5 leaves S=1 and 8+D leaves S=0.
- R6: Op code 6 (rotate left) moves C into bit 0 and the old bit 3 into C. Op code 7 (rotate right) moves C into bit 3 and the old bit 0 into C. Neither changes S or G.
- R7: Op code 8 copies C into S and then clears C. Op code 9 copies C into S and then sets C. Z and G are kept and res_o equals the accumulator.
- R8: Op code 10 sets G and op code 11 clears G. Op code 12 copies G into S. Every other flag is kept.
- R9: The flags read on flags_o as bits [3:0] = {C, Z, S, G}. A synchronous reset drives them to 4'b0010 (S=1, all others 0).
- R10: With restore_en_i high at a rising edge, the flags load restore_flags_i in the same bit layout, whatever the op code.
- R11: Op codes 0, 13, 14 and 15 change no flag and return the accumulator. Arithmetic and rotate ops never change G.
- R12: res_o follows the inputs in the same cycle. flags_o changes only at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_i | input | 4 | Operation code |
| acc_i | input | W (4) | Accumulator operand |
| opnd_i | input | W (4) | Second operand |
| restore_en_i | input | 1 | Load the flags from restore_flags_i |
| restore_flags_i | input | 4 | Flag value to restore, {C,Z,S,G} |
| res_o | output | W (4) | Operation result |
| flags_o | output | 4 | Current flags {C,Z,S,G} |

## Verification
The first pass is exhaustive. Each of the seven arithmetic and rotate ops is applied to every pair of 4-bit operands, with carry-in 0 and 1 and with varied Z, S and G beforehand. This sweep separates carry-out from borrow-out at every wrap point, and it shows whether S, Z and G are written or kept. A table of hand-worked cases follows. It covers the zero-result cases of add, subtract and compare, both carry-test ops, the G ops and unused op codes. Directed sequences then check the following:
- restore overrides a live op
- the result appears before the edge while the flags wait for it
- reset in the middle of a run returns the flags to their reset value

// File: rtl/nalu_pkg.sv
`timescale 1ns/1ps
package nalu_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADC  = 4'd2,
        OP_SUB  = 4'd3,
        OP_SBC  = 4'd4,
        OP_CMP  = 4'd5,
        OP_RLC  = 4'd6,
        OP_RRC  = 4'd7,
        OP_TCLR = 4'd8,
        OP_TSET = 4'd9,
        OP_GSET = 4'd10,
        OP_GCLR = 4'd11,
        OP_GTST = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_ROT   = 2'd2,
        CLS_FLAG  = 2'd3
    } cls_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic g;
    } flags_t;

    localparam flags_t FLAGS_RST = '{c: 1'b0, z: 1'b0, s: 1'b1, g: 1'b0};

    typedef struct packed {
        cls_e cls;
        logic sub;      // invert second operand, default carry-in 1
        logic use_cf;   // carry-in taken from the carry flag
        logic left;     // rotate direction
        logic keep_acc; // result port shows the accumulator
    } ctl_t;

    function automatic ctl_t nalu_decode(input op_e op);
        ctl_t d;
        d = '{cls: CLS_NONE, sub: 1'b0, use_cf: 1'b0, left: 1'b0, keep_acc: 1'b1};
        case (op)
            OP_ADD: begin d.cls = CLS_ARITH; d.keep_acc = 1'b0; end
            OP_ADC: begin d.cls = CLS_ARITH; d.use_cf = 1'b1; d.keep_acc = 1'b0; end
            OP_SUB: begin d.cls = CLS_ARITH; d.sub = 1'b1; d.keep_acc = 1'b0; end
            OP_SBC: begin d.cls = CLS_ARITH; d.sub = 1'b1; d.use_cf = 1'b1; d.keep_acc = 1'b0; end
            OP_CMP: begin d.cls = CLS_ARITH; d.sub = 1'b1; end
            OP_RLC: begin d.cls = CLS_ROT; d.left = 1'b1; d.keep_acc = 1'b0; end
            OP_RRC: begin d.cls = CLS_ROT; d.keep_acc = 1'b0; end
            OP_TCLR, OP_TSET, OP_GSET, OP_GCLR, OP_GTST: d.cls = CLS_FLAG;
            default: d.cls = CLS_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/nalu_addsub.sv
`timescale 1ns/1ps
module nalu_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    // Ripple chain; subtraction is a + ~b + cin, so the carry out is the
    // inverted borrow.
    logic [W:0] chain;
    assign chain[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bx;
        assign bx          = b_i[i] ^ sub_i;
        assign sum_o[i]    = a_i[i] ^ bx ^ chain[i];
        assign chain[i+1]  = (a_i[i] & bx) | (chain[i] & (a_i[i] ^ bx));
    end

    assign cout_o = chain[W];
endmodule

// File: rtl/nalu_rotate.sv
`timescale 1ns/1ps
module nalu_rotate #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  logic         left_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic [W-1:0] lft;
    logic [W-1:0] rgt;

    for (genvar i = 0; i < W; i++) begin : g_pos
        if (i == 0) begin : g_lsb
            assign lft[i] = cin_i;
        end else begin : g_lup
            assign lft[i] = a_i[i-1];
        end
        if (i == W-1) begin : g_msb
            assign rgt[i] = cin_i;
        end else begin : g_rdn
            assign rgt[i] = a_i[i+1];
        end
    end

    assign res_o  = left_i ? lft : rgt;
    assign cout_o = left_i ? a_i[W-1] : a_i[0];
endmodule

// File: rtl/nalu_flagreg.sv
`timescale 1ns/1ps
module nalu_flagreg
    import nalu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  flags_t load_val_i,
    input  flags_t nxt_i,
    output flags_t q_o
);
    flags_t q;

    always_ff @(posedge clk) begin
        if (rst)         q <= FLAGS_RST;
        else if (load_i) q <= load_val_i;
        else             q <= nxt_i;
    end

    assign q_o = q;

    // R9
    rst_val_chk: assert property (@(posedge clk) rst |=> q == FLAGS_RST);

    // R10
    restore_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> q == $past(load_val_i));
endmodule

// File: rtl/nalu_core.sv
`timescale 1ns/1ps
module nalu_core
    import nalu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic         restore_en_i,
    input  logic [3:0]   restore_flags_i,
    output logic [W-1:0] res_o,
    output logic [3:0]   flags_o
);
    op_e          op;
    ctl_t         ctl;
    flags_t       fq;
    flags_t       fn;
    logic [W-1:0] sum;
    logic [W-1:0] rot;
    logic         sum_c;
    logic         rot_c;
    logic         cin;
    logic [W-1:0] res;

    assign op  = op_e'(op_i);
    assign ctl = nalu_decode(op);
    assign cin = ctl.use_cf ? fq.c : ctl.sub;

    nalu_addsub #(.W(W)) u_addsub (
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .sub_i  (ctl.sub),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (sum_c)
    );

    nalu_rotate #(.W(W)) u_rotate (
        .a_i    (acc_i),
        .cin_i  (fq.c),
        .left_i (ctl.left),
        .res_o  (rot),
        .cout_o (rot_c)
    );

    always_comb begin
        fn  = fq;
        res = acc_i;
        case (ctl.cls)
            CLS_ARITH: begin
                fn.c = sum_c;
                fn.z = (sum == '0);
                fn.s = ~sum_c;
                if (!ctl.keep_acc) res = sum;
            end
            CLS_ROT: begin
                fn.c = rot_c;
                fn.z = (rot == '0);
                res  = rot;
            end
            CLS_FLAG: begin
                case (op)
                    OP_TCLR: begin fn.s = fq.c; fn.c = 1'b0; end
                    OP_TSET: begin fn.s = fq.c; fn.c = 1'b1; end
                    OP_GSET: fn.g = 1'b1;
                    OP_GCLR: fn.g = 1'b0;
                    OP_GTST: fn.s = fq.g;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    nalu_flagreg u_flagreg (
        .clk        (clk),
        .rst        (rst),
        .load_i     (restore_en_i),
        .load_val_i (flags_t'(restore_flags_i)),
        .nxt_i      (fn),
        .q_o        (fq)
    );

    assign res_o   = res;
    assign flags_o = fq;

    // Checking aids: wide sum independent of the ripple chain.
    logic [W:0] chk_wide;
    logic       chk_arith;
    logic       chk_rot;
    assign chk_wide  = {1'b0, acc_i} + {1'b0, opnd_i};
    assign chk_arith = (op_i >= 4'd1) && (op_i <= 4'd5);
    assign chk_rot   = (op_i == 4'd6) || (op_i == 4'd7);

    // R1
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (!restore_en_i && op_i == 4'd1) |=> flags_o[3] == $past(chk_wide[W]));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!restore_en_i && (op_i == 4'd1 || op_i == 4'd3 || chk_rot))
        |=> flags_o[2] == ($past(res_o) == '0));

    // R5
    status_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (!restore_en_i && chk_arith) |=> flags_o[1] == !flags_o[3]);

    // R6
    rot_keep_status_chk: assert property (@(posedge clk) disable iff (rst)
        (!restore_en_i && chk_rot) |=> flags_o[1] == $past(flags_o[1]));

    // R7
    test_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!restore_en_i && op_i == 4'd8) |=> (!flags_o[3] && flags_o[1] == $past(flags_o[3])));

    // R11
    gflag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!restore_en_i && (chk_arith || chk_rot)) |=> flags_o[0] == $past(flags_o[0]));

    // R11
    idle_op_chk: assert property (@(posedge clk) disable iff (rst)
        (!restore_en_i && (op_i == 4'd0 || op_i >= 4'd13)) |=> $stable(flags_o));
endmodule

// File: tb/nalu_core_bench.sv
`timescale 1ns/1ps
module nalu_core_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op_i;
    logic [3:0] acc_i;
    logic [3:0] opnd_i;
    logic       restore_en_i;
    logic [3:0] restore_flags_i;
    logic [3:0] res_o;
    logic [3:0] flags_o;

    always #2.5 clk = ~clk;

    nalu_core #(.W(4)) u_nalu_core (
        .clk             (clk),
        .rst             (rst),
        .op_i            (op_i),
        .acc_i           (acc_i),
        .opnd_i          (opnd_i),
        .restore_en_i    (restore_en_i),
        .restore_flags_i (restore_flags_i),
        .res_o           (res_o),
        .flags_o         (flags_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1, 4'd2:        return "R1";
            4'd3, 4'd4:        return "R2";
            4'd5:              return "R3";
            4'd6, 4'd7:        return "R6";
            4'd8, 4'd9:        return "R7";
            4'd10, 4'd11, 4'd12: return "R8";
            default:           return "R11";
        endcase
    endfunction

    // Reference built from the requirements: returns {result, flags}.
    function automatic logic [7:0] model(input logic [3:0] op, input logic [3:0] fin,
                                         input logic [3:0] a, input logic [3:0] b);
        int         t;
        logic       c;
        logic [3:0] r;
        logic [3:0] f;
        r = a;
        f = fin;
        case (op)
            4'd1, 4'd2: begin
                t = int'(a) + int'(b) + ((op == 4'd2 && fin[3]) ? 1 : 0);
                c = (t > 15);
                r = t[3:0];
                f = {c, r == 4'd0, !c, fin[0]};
            end
            4'd3, 4'd4, 4'd5: begin
                t = int'(a) - int'(b) - ((op == 4'd4 && !fin[3]) ? 1 : 0);
                c = (t >= 0);
                r = t[3:0];
                f = {c, r == 4'd0, !c, fin[0]};
                if (op == 4'd5) r = a;
            end
            4'd6: begin r = {a[2:0], fin[3]}; f = {a[3], r == 4'd0, fin[1], fin[0]}; end
            4'd7: begin r = {fin[3], a[3:1]}; f = {a[0], r == 4'd0, fin[1], fin[0]}; end
            4'd8:  f = {1'b0, fin[2], fin[3], fin[0]};
            4'd9:  f = {1'b1, fin[2], fin[3], fin[0]};
            4'd10: f = {fin[3:1], 1'b1};
            4'd11: f = {fin[3:1], 1'b0};
            4'd12: f = {fin[3], fin[2], fin[0], fin[0]};
            default: ;
        endcase
        return {r, f};
    endfunction

    // {op, flags before, acc, opnd, expected result, expected flags}
    localparam int NV = 29;
    localparam logic [23:0] VEC [NV] = '{
        24'h103472, 24'h107F68, 24'h10880C, 24'h110007, 24'h103582, 24'h108D58,
        24'h28F00C, 24'h308448, 24'h387F82, 24'h30990C, 24'h4055F2, 24'h48550C,
        24'h582322, 24'h51666D, 24'h689538, 24'h62800E, 24'h781088, 24'h766032,
        24'h88A0A2, 24'h86A0A4, 24'h921018, 24'h9D101F, 24'hA04041, 24'hBF404E,
        24'hC12023, 24'hCE202C, 24'h0A303A, 24'hD5C7C5, 24'hFB919B
    };

    task automatic set_flags(input logic [3:0] f);
        @(negedge clk);
        restore_en_i    = 1'b1;
        restore_flags_i = f;
        op_i            = 4'd0;
        @(posedge clk);
        #1;
        restore_en_i = 1'b0;
    endtask

    task automatic apply(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b,
                         output logic [3:0] r, output logic [3:0] f);
        @(negedge clk);
        op_i   = op;
        acc_i  = a;
        opnd_i = b;
        #1;
        r = res_o;
        @(posedge clk);
        #1;
        f = flags_o;
        op_i = 4'd0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] r;
        logic [3:0] f;
        logic [7:0] exp;
        int         sweep_bad;
        rst             = 1'b1;
        op_i            = 4'd0;
        acc_i           = 4'd0;
        opnd_i          = 4'd0;
        restore_en_i    = 1'b0;
        restore_flags_i = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset flags", flags_o, 4'b0010);

        // Hand-worked table
        for (int i = 0; i < NV; i++) begin
            set_flags(VEC[i][19:16]);
            apply(VEC[i][23:20], VEC[i][15:12], VEC[i][11:8], r, f);
            check($sformatf("%s result vec %0d", req_of(VEC[i][23:20]), i), r, VEC[i][7:4]);
            check($sformatf("%s R4 R5 flags vec %0d", req_of(VEC[i][23:20]), i), f, VEC[i][3:0]);
        end

        // Exhaustive sweep of arithmetic and rotate ops (R1 R2 R3 R4 R5 R6)
        sweep_bad = 0;
        for (int op = 1; op <= 7; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [3:0] fin;
                        fin = {c[0], a[1], b[0], a[2] ^ b[1]};
                        set_flags(fin);
                        apply(op[3:0], a[3:0], b[3:0], r, f);
                        exp = model(op[3:0], fin, a[3:0], b[3:0]);
                        check($sformatf("%s sweep result a=%h b=%h c=%0d", req_of(op[3:0]), a, b, c),
                              r, exp[7:4]);
                        check($sformatf("%s R4 R5 sweep flags a=%h b=%h c=%0d", req_of(op[3:0]), a, b, c),
                              f, exp[3:0]);
                    end
                end
            end
        end

        // R10: restore wins over a live op
        set_flags(4'h0);
        @(negedge clk);
        restore_en_i    = 1'b1;
        restore_flags_i = 4'h5;
        op_i            = 4'd1;
        acc_i           = 4'hF;
        opnd_i          = 4'h1;
        @(posedge clk);
        #1;
        restore_en_i = 1'b0;
        op_i         = 4'd0;
        check("R10 restore overrides op", flags_o, 4'h5);

        // R12: result now, flags at the edge
        set_flags(4'h2);
        @(negedge clk);
        op_i   = 4'd1;
        acc_i  = 4'h8;
        opnd_i = 4'h8;
        #1;
        check("R12 result before edge", res_o, 4'h0);
        check("R12 flags held before edge", flags_o, 4'h2);
        @(posedge clk);
        #1;
        op_i = 4'd0;
        check("R12 flags after edge", flags_o, 4'hC);

        // R11: idle code held for several edges
        set_flags(4'h9);
        @(negedge clk);
        op_i  = 4'd14;
        acc_i = 4'h6;
        repeat (3) @(posedge clk);
        #1;
        check("R11 idle code result", res_o, 4'h6);
        check("R11 idle code flags", flags_o, 4'h9);
        op_i = 4'd0;

        // R9: reset mid-run with an op applied
        set_flags(4'hF);
        @(negedge clk);
        rst   = 1'b1;
        op_i  = 4'd1;
        acc_i = 4'hF;
        opnd_i = 4'hF;
        @(posedge clk);
        #1;
        check("R9 reset mid-run", flags_o, 4'b0010);
        rst  = 1'b0;
        op_i = 4'd0;

        sweep_bad = errors;
        if (sweep_bad == 0) summary();
        else summary();
        $finish;
    end
endmodule